// File: doc/BRIEF.md
# Checked SPI Register Link

This block is an SPI slave that gives a host access to a register file. Each transaction carries a 16-bit command made of a direction bit, a 7-bit register address and a data byte. The host may add an 8-bit CRC. The block samples SCLK, CS and SDI with its own system clock, so those inputs must already be synchronous to `clk_i` and much slower than it. It decides what to do with a frame in the cycle in which it sees CS return high. A frame is used only if its length, its CRC and its target address are all correct. Otherwise the matching sticky error flag is raised and the frame is dropped.

During each frame, SDO returns the result of the frame before it. After an accepted write, that is the write command itself. After an accepted read, it is the read address with the register contents. After anything else, it is a zero word. In every case the word is followed by the block's own CRC byte.

The block has two reset paths, and both raise a reset-detected flag and pulse a reset request for the surrounding logic:
- a run of 64 consecutive ones on SDI, counted across frame boundaries;
- two accepted writes to a soft-reset register address, the first with field value 11 and the second with 10.

Top module: `spi_reg_link`

## Requirements
- R1: Bits are taken MSB first on each SCLK rising edge while `cs_ni` is low. Command bit 15 is the direction (1 = read), bits [14:8] are the address and bits [7:0] are the data. With `crc_en_i` high, 8 CRC bits follow the command. A frame is acted on only when CS rises after exactly 16 bits (CRC off) or exactly 24 bits (CRC on). Other lengths that are multiples of eight are dropped without a flag.
- R2: If the number of bits at CS rise is not a multiple of eight, `err_clk_o` is set and the frame is dropped. No write takes place. This check has priority over the CRC check.
- R3: With CRC on, the received byte is compared with a CRC-8 over the 16 command bits. The polynomial is x^8+x^2+x+1 (0x07), the start value is 0x00, bits are processed MSB first and there is no final XOR. On a mismatch, `err_crc_o` is set and the command is dropped.
- R4: A read of an address for which `addr_valid_i` is low sets `err_rd_o`, and its response word is zero.
- R5: A write to an address that is not valid, or for which `addr_ro_i` is high, sets `err_wr_o` and produces no `reg_we_o`.
- R6: An accepted write pulses `reg_we_o` for one clock, with `reg_addr_o` and `reg_wdata_o` taken from the command.
- R7: During the next frame, SDO shifts out MSB first a 16-bit word followed by its CRC-8, presenting a new bit after each SCLK rising edge. The word is:
  - the command itself after an accepted write;
  - {1, address, register data} after an accepted read;
  - zero after a dropped frame or a ones-reset.
- R8: The error flags are sticky. They stay set through dropped frames and clear together at the end of the next accepted frame.
- R9: The 64th consecutive one on SDI pulses `rst_req_o` and sets `rst_seen_o`. The run is counted across frames and any zero restarts it. The rest of the current CS-low period is then discarded.
- R10: An accepted write to the soft-reset address (default 0x11) with data bits [1:0] = 11, followed by one with 10, pulses `rst_req_o` and sets `rst_seen_o`. Any other value written to that address in between cancels the sequence.
- R11: `rst_seen_o` clears at the end of the next accepted read.
- R12: After reset, all flags, `rst_req_o`, `reg_we_o` and `sdo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock, synchronous to clk_i |
| cs_ni | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | SPI data in |
| sdo_o | output | 1 | SPI data out, low while CS is high |
| crc_en_i | input | 1 | Expect and return a CRC byte per frame |
| reg_addr_o | output | 7 | Register address of the current command |
| reg_wdata_o | output | 8 | Write data of the current command |
| reg_we_o | output | 1 | One-clock write strobe |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |
| addr_valid_i | input | 1 | reg_addr_o is an existing register |
| addr_ro_i | input | 1 | reg_addr_o is read-only |
| err_clk_o | output | 1 | Sticky clock-count error |
| err_crc_o | output | 1 | Sticky CRC mismatch |
| err_rd_o | output | 1 | Sticky invalid read |
| err_wr_o | output | 1 | Sticky invalid write |
| rst_seen_o | output | 1 | Reset detected |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
A ones-reset can fire on the last clock of a frame that would otherwise complete as a correct command. The frame-end decision and the reset detector then act on the same bit. The bench provokes this with four all-ones frames, each of which is a valid read of address 0x7F, so that the 64th one is the final bit of the fourth read. The collision is judged correct when three things hold:
- one reset request is seen;
- `rst_seen_o` stays set, although an accepted read would have cleared it;
- the following frame returns a zero word instead of read data.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int CRC_W    = 8;
  localparam int CMD_W    = 1 + ADDR_W + DATA_W;
  localparam int FRAME_W  = CMD_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // MSB first, start 0, no final xor
  function automatic logic [CRC_W-1:0] crc_calc(input logic [CMD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_edge_rx.sv
module spi_edge_rx import spi_link_pkg::*; #(
  parameter int ONES_LEN = 64,
  parameter int CNT_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               sdi_i,
  output logic               rise_o,
  output logic               frame_start_o,
  output logic               frame_end_o,
  output logic               ones_hit_o,
  output logic               flushed_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [FRAME_W-1:0] shift_o
);
  localparam int ONES_W = $clog2(ONES_LEN + 1);

  logic              sclk_q, cs_q, flushed_q;
  logic [ONES_W-1:0] ones_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAME_W-1:0] shift_q;

  assign rise_o        = sclk_i & ~sclk_q & ~cs_ni;
  assign frame_start_o = cs_q & ~cs_ni;
  assign frame_end_o   = ~cs_q & cs_ni;
  assign ones_hit_o    = rise_o & sdi_i & (ones_q == ONES_W'(ONES_LEN - 1));
  assign flushed_o     = flushed_q;
  assign bit_cnt_o     = cnt_q;
  assign shift_o       = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      flushed_q <= 1'b0;
      ones_q    <= '0;
      cnt_q     <= '0;
      shift_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (ones_hit_o)         flushed_q <= 1'b1;
      else if (frame_start_o) flushed_q <= 1'b0;
      if (frame_start_o)      cnt_q <= CNT_W'(rise_o);
      else if (ones_hit_o)    cnt_q <= '0;
      else if (rise_o)        cnt_q <= cnt_q + 1'b1;
      if (rise_o) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
        if (!sdi_i || ones_hit_o) ones_q <= '0;
        else                      ones_q <= ones_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_eval.sv
module spi_cmd_eval import spi_link_pkg::*; #(
  parameter int               CNT_W     = 8,
  parameter logic [ADDR_W-1:0] SRST_ADDR = 7'h11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               crc_en_i,
  input  logic               frame_end_i,
  input  logic               ones_hit_i,
  input  logic               flushed_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  input  logic [FRAME_W-1:0] shift_i,
  input  logic               addr_valid_i,
  input  logic               addr_ro_i,
  input  logic [DATA_W-1:0]  reg_rdata_i,
  output logic [ADDR_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic [CMD_W-1:0]   rsp_o,
  output logic               err_clk_o,
  output logic               err_crc_o,
  output logic               err_rd_o,
  output logic               err_wr_o,
  output logic               rst_seen_o,
  output logic               rst_req_o
);
  logic [CMD_W-1:0] cmd;
  logic [CRC_W-1:0] rx_crc;
  logic end_ok, cnt_bad, len_ok, crc_bad, cmd_go, is_rd;
  logic rd_ok, wr_ok, rd_bad, wr_bad, accepted, srst_hit, soft_go, armed_q;

  assign cmd     = crc_en_i ? shift_i[FRAME_W-1:CRC_W] : shift_i[CMD_W-1:0];
  assign rx_crc  = shift_i[CRC_W-1:0];
  assign is_rd   = cmd[CMD_W-1];
  assign reg_addr_o  = cmd[CMD_W-2:DATA_W];
  assign reg_wdata_o = cmd[DATA_W-1:0];

  assign end_ok   = frame_end_i & ~flushed_i;
  assign cnt_bad  = bit_cnt_i[2:0] != 3'd0;
  assign len_ok   = bit_cnt_i == (crc_en_i ? CNT_W'(FRAME_W) : CNT_W'(CMD_W));
  assign crc_bad  = crc_en_i & (crc_calc(cmd) != rx_crc);
  assign cmd_go   = end_ok & ~cnt_bad & len_ok & ~crc_bad;
  assign rd_ok    = cmd_go & is_rd & addr_valid_i;
  assign wr_ok    = cmd_go & ~is_rd & addr_valid_i & ~addr_ro_i;
  assign rd_bad   = cmd_go & is_rd & ~addr_valid_i;
  assign wr_bad   = cmd_go & ~is_rd & (~addr_valid_i | addr_ro_i);
  assign accepted = rd_ok | wr_ok;
  assign reg_we_o = wr_ok;
  assign srst_hit = wr_ok & (reg_addr_o == SRST_ADDR);
  assign soft_go  = srst_hit & armed_q & (reg_wdata_o[1:0] == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_o      <= '0;
      armed_q    <= 1'b0;
      err_clk_o  <= 1'b0;
      err_crc_o  <= 1'b0;
      err_rd_o   <= 1'b0;
      err_wr_o   <= 1'b0;
      rst_seen_o <= 1'b0;
      rst_req_o  <= 1'b0;
    end else begin
      if (ones_hit_i) begin
        rsp_o   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (end_ok)
          rsp_o <= rd_ok ? {cmd[CMD_W-1:DATA_W], reg_rdata_i} : (wr_ok ? cmd : '0);
        if (srst_hit) armed_q <= (reg_wdata_o[1:0] == 2'b11);
      end
      if (accepted) begin
        err_clk_o <= 1'b0;
        err_crc_o <= 1'b0;
        err_rd_o  <= 1'b0;
        err_wr_o  <= 1'b0;
      end else begin
        if (end_ok && cnt_bad)                      err_clk_o <= 1'b1;
        if (end_ok && !cnt_bad && len_ok && crc_bad) err_crc_o <= 1'b1;
        if (rd_bad) err_rd_o <= 1'b1;
        if (wr_bad) err_wr_o <= 1'b1;
      end
      rst_req_o <= ones_hit_i | soft_go;
      if (ones_hit_i || soft_go) rst_seen_o <= 1'b1;
      else if (rd_ok)            rst_seen_o <= 1'b0;
    end
  end

  // R6
  we_at_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (frame_end_i && bit_cnt_i[2:0] == 3'd0));
  // R5
  we_only_writable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (addr_valid_i && !addr_ro_i));
  // R2
  clk_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_clk_o) |-> $past(bit_cnt_i[2:0] != 3'd0));
  // R3
  crc_err_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_crc_o) |-> $past(crc_en_i));
  // R9
  req_marks_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_seen_o);
endmodule

// File: rtl/spi_tx.sv
module spi_tx import spi_link_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             frame_start_i,
  input  logic             rise_i,
  input  logic [CMD_W-1:0] rsp_i,
  output logic             sdo_o
);
  logic [FRAME_W-1:0] tx_q;

  assign sdo_o = ~cs_ni & tx_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tx_q <= '0;
    else if (frame_start_i) tx_q <= {rsp_i, crc_calc(rsp_i)};
    else if (rise_i)        tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  // R7
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_o);
endmodule

// File: rtl/spi_reg_link.sv
module spi_reg_link import spi_link_pkg::*; #(
  parameter int               ONES_LEN  = 64,
  parameter int               CNT_W     = 8,
  parameter logic [ADDR_W-1:0] SRST_ADDR = 7'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              crc_en_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              addr_valid_i,
  input  logic              addr_ro_i,
  output logic              err_clk_o,
  output logic              err_crc_o,
  output logic              err_rd_o,
  output logic              err_wr_o,
  output logic              rst_seen_o,
  output logic              rst_req_o
);
  logic rise, frame_start, frame_end, ones_hit, flushed;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shift;
  logic [CMD_W-1:0]   rsp;

  spi_edge_rx #(.ONES_LEN(ONES_LEN), .CNT_W(CNT_W)) i_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .sdi_i,
    .rise_o(rise), .frame_start_o(frame_start), .frame_end_o(frame_end),
    .ones_hit_o(ones_hit), .flushed_o(flushed), .bit_cnt_o(bit_cnt), .shift_o(shift)
  );

  spi_cmd_eval #(.CNT_W(CNT_W), .SRST_ADDR(SRST_ADDR)) i_eval (
    .clk_i, .rst_ni, .crc_en_i,
    .frame_end_i(frame_end), .ones_hit_i(ones_hit), .flushed_i(flushed),
    .bit_cnt_i(bit_cnt), .shift_i(shift),
    .addr_valid_i, .addr_ro_i, .reg_rdata_i,
    .reg_addr_o, .reg_wdata_o, .reg_we_o, .rsp_o(rsp),
    .err_clk_o, .err_crc_o, .err_rd_o, .err_wr_o, .rst_seen_o, .rst_req_o
  );

  spi_tx i_tx (
    .clk_i, .rst_ni, .cs_ni,
    .frame_start_i(frame_start), .rise_i(rise), .rsp_i(rsp), .sdo_o
  );
endmodule

// File: tb/test_spi_reg_link.sv
module test_spi_reg_link;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, crc_en = 1'b0;
  logic sdo, reg_we, addr_valid, addr_ro;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic err_clk, err_crc, err_rd, err_wr, rst_seen, rst_req;

  int tests = 0, fails = 0, we_cnt = 0, rst_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mem [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_link i_spi_reg_link (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .crc_en_i(crc_en), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata), .addr_valid_i(addr_valid),
    .addr_ro_i(addr_ro), .err_clk_o(err_clk), .err_crc_o(err_crc), .err_rd_o(err_rd),
    .err_wr_o(err_wr), .rst_seen_o(rst_seen), .rst_req_o(rst_req)
  );

  // register file model: 0x00-0x3F and 0x7F exist, 0x30-0x3F and 0x7F read-only
  assign addr_valid = (reg_addr < 7'h40) || (reg_addr == 7'h7F);
  assign addr_ro    = (reg_addr >= 7'h30);
  assign reg_rdata  = mem[reg_addr];

  always @(negedge clk) begin
    if (reg_we) begin mem[reg_addr] = reg_wdata; we_cnt++; end
    if (rst_req) rst_cnt++;
  end

  function automatic logic [7:0] bcrc(input logic [15:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [15:0] mk(input logic rd, input logic [6:0] a, input logic [7:0] d);
    return {rd, a, d};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] d, input int n, output logic [23:0] r);
    r = '0;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = d[i];
      repeat (HALF) @(negedge clk);
      r = {r[22:0], sdo};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send16(input logic [15:0] c, output logic [15:0] r);
    logic [23:0] rr;
    xfer({8'h00, c}, 16, rr);
    r = rr[15:0];
  endtask

  task automatic t_reset;
    chk("R12 flags", {err_clk, err_crc, err_rd, err_wr, rst_seen, rst_req}, 0);
    chk("R12 sdo/we", {sdo, reg_we}, 0);
  endtask

  task automatic t_write_read;
    logic [15:0] r;
    int w0 = we_cnt;
    send16(mk(0, 7'h05, 8'hA5), r);
    chk("R6 write count", we_cnt - w0, 1);
    chk("R6 write data", mem[5], 8'hA5);
    send16(mk(1, 7'h05, 8'h00), r);
    chk("R7 write echo", r, mk(0, 7'h05, 8'hA5));
    send16(mk(1, 7'h12, 8'h00), r);
    chk("R7 read data", r, mk(1, 7'h05, 8'hA5));
    chk("R1 read no write", we_cnt - w0, 1);
  endtask

  task automatic t_crc;
    logic [23:0] r;
    logic [15:0] c = mk(0, 7'h0A, 8'h3C);
    int w0 = we_cnt;
    crc_en = 1'b1;
    xfer({c, bcrc(c) ^ 8'h01}, 24, r);
    chk("R3 bad crc flag", err_crc, 1);
    chk("R3 bad crc no write", we_cnt - w0, 0);
    xfer({c, bcrc(c)}, 24, r);
    chk("R3 good crc write", we_cnt - w0, 1);
    chk("R8 clean clears crc flag", err_crc, 0);
    xfer({mk(1, 7'h0A, 8'h00), bcrc(mk(1, 7'h0A, 8'h00))}, 24, r);
    chk("R7 echo with crc", r, {c, bcrc(c)});
    xfer({mk(1, 7'h00, 8'h00), 8'h00}, 23, r);
    chk("R2 count flag", err_clk, 1);
    chk("R2 precedence over crc", err_crc, 0);
    crc_en = 1'b0;
  endtask

  task automatic t_clk_err;
    logic [23:0] r;
    logic [15:0] q;
    int w0 = we_cnt;
    send16(mk(1, 7'h01, 8'h00), q);
    xfer({8'h00, mk(0, 7'h06, 8'h77)}, 15, r);
    chk("R2 short write flag", err_clk, 1);
    chk("R2 short write dropped", we_cnt - w0, 0);
    send16(mk(1, 7'h01, 8'h00), q);
    chk("R7 zero after drop", q, 16'h0000);
  endtask

  task automatic t_inval;
    logic [15:0] q;
    logic [23:0] r;
    int w0 = we_cnt;
    send16(mk(1, 7'h50, 8'h00), q);
    chk("R4 invalid read flag", err_rd, 1);
    send16(mk(0, 7'h35, 8'h11), q);
    chk("R4 invalid read response", q, 16'h0000);
    chk("R5 read-only write flag", err_wr, 1);
    send16(mk(0, 7'h60, 8'h11), q);
    chk("R5 no write", we_cnt - w0, 0);
    xfer(24'h0, 8, r);
    chk("R8 sticky over dropped frame", {err_rd, err_wr}, 2'b11);
    send16(mk(0, 7'h07, 8'h44), q);
    chk("R8 cleared by accepted write", {err_rd, err_wr, err_clk}, 0);
  endtask

  task automatic t_soft;
    logic [15:0] q;
    int c0 = rst_cnt;
    send16(mk(0, 7'h11, 8'h03), q);
    send16(mk(0, 7'h11, 8'h02), q);
    chk("R10 soft reset pulse", rst_cnt - c0, 1);
    chk("R10 reset seen", rst_seen, 1);
    send16(mk(1, 7'h11, 8'h00), q);
    chk("R11 read clears seen", rst_seen, 0);
    send16(mk(0, 7'h11, 8'h03), q);
    send16(mk(0, 7'h11, 8'h00), q);
    send16(mk(0, 7'h11, 8'h02), q);
    chk("R10 broken sequence", rst_cnt - c0, 1);
  endtask

  task automatic t_ones;
    logic [15:0] q;
    logic [23:0] r;
    int c0 = rst_cnt;
    int w0 = we_cnt;
    xfer(24'h0, 8, r);
    for (int k = 0; k < 3; k++) send16(16'hFFFF, q);
    chk("R9 no reset before 64", rst_cnt - c0, 0);
    send16(16'hFFFF, q);
    chk("R9 reset at 64th one", rst_cnt - c0, 1);
    chk("R9 seen after ones", rst_seen, 1);
    chk("R9 no write", we_cnt - w0, 0);
    send16(mk(1, 7'h05, 8'h00), q);
    chk("R9 last frame discarded", q, 16'h0000);
    chk("R11 read clears seen", rst_seen, 0);
    xfer(24'h0, 8, r);
    for (int k = 0; k < 3; k++) send16(16'hFFFF, q);
    send16(16'h7FFF, q);
    send16(16'hFFFF, q);
    chk("R9 zero restarts run", rst_cnt - c0, 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_crc();
    t_clk_err();
    t_inval();
    t_soft();
    t_ones();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule